// File: doc/BRIEF.md
# Reset and Interrupt Vector Fetch Sequencer

This block starts program execution. It runs after power-on reset, after a synchronous reset request, and when an interrupt is accepted. Each time, it reads a two-byte vector from program ROM and loads the program counter together with the two bank-enable flags. Every vector pair packs both flags into the top two bits of its first byte, beside a 14-bit start address. A single load therefore sets the flags and the start location in the same cycle.

Seven interrupt request lines are served in a fixed order: the source whose vector pair sits lowest in ROM wins. The accepted source receives a one-cycle acknowledge. The sequencer then gives a one-cycle context-save strobe, so the core can capture the outgoing PC and flags before they are replaced. The ROM port returns data one cycle after the address is presented. The busy output tells the core that a fetch is in progress.

Top module: `vector_fetch_seq`

## Requirements
- R1: While rst_ni is low, busy_o is 1, rom_rd_o is 0, and pc_o, mbe_o, rbe_o, irq_ack_o and save_o are all 0. After release, the reset pair is read at 0000h and then at 0001h.
- R2: The first vector byte gives mbe_o in bit 7, rbe_o in bit 6 and pc_o[13:8] in bits 5:0. The second byte gives pc_o[7:0]. pc_o[14] is always loaded as 0, so every start address is at most 3FFFh.
- R3: The ROM returns data one cycle after the address. The sequencer reads the even address in one cycle and the next odd address in the following cycle. The new PC and flags appear on the outputs two cycles after the second read.
- R4: Interrupt line k (irq_i[k], k = 0..6) uses the vector pair at 2k+2. The lines are, in order: interval timer / external 4, external 0, external 1, serial 0, timer 0, pulse generator, key scan. Their pairs are at 0002h, 0004h, 0006h, 0008h, 000Ah, 000Ch and 000Eh.
- R5: When several lines are pending, the lowest index is served. irq_ack_o goes high for exactly one cycle, with only that bit set, in the cycle after the request is seen while idle.
- R6: save_o goes high for exactly one cycle per interrupt fetch, in the same cycle as the acknowledge and before the first ROM read. A reset fetch never raises save_o.
- R7: busy_o goes high in the cycle after an interrupt is accepted and stays high for exactly four cycles. pc_o does not change while busy_o is high.
- R8: reset_req_i overrides any fetch in progress and any pending request. The next read goes to 0000h, no acknowledge is given, and the abandoned vector is never loaded.
- R9: Requests that arrive while busy_o is high are not acknowledged until the current fetch completes. They are then served in priority order.
- R10: rom_rd_o is high only in the two read cycles of each fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; a reset fetch follows its release |
| reset_req_i | input | 1 | Synchronous request to restart from the reset vector |
| irq_i | input | NUM_IRQ | Level interrupt requests, bit 0 highest priority |
| irq_ack_o | output | NUM_IRQ | One-cycle acknowledge of the accepted request |
| rom_rd_o | output | 1 | ROM read strobe |
| rom_addr_o | output | PC_W | ROM byte address |
| rom_data_i | input | 8 | ROM data, valid one cycle after the address |
| pc_o | output | PC_W | Program counter |
| mbe_o | output | 1 | Memory bank enable flag |
| rbe_o | output | 1 | Register bank enable flag |
| save_o | output | 1 | One-cycle strobe to capture the old PC and flags |
| busy_o | output | 1 | Fetch in progress |

## Verification
The bench builds the block with NUM_IRQ = 7 and PC_W = 15. With these values every one of the seven vector pairs is fetched at its real address. The widest start address, 3FFFh, can be loaded while the top PC bit stays at zero. The 15-bit width also lets a vector byte with bits 7:6 set show that the flags never spill into the PC.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_SAVE,
    ST_RD_HI,
    ST_RD_LO,
    ST_FIN
  } seq_state_e;

  localparam int BYTE_W   = 8;
  localparam int START_W  = 14;
  localparam int MBE_BIT  = 7;
  localparam int RBE_BIT  = 6;
  localparam int HI_ADR_W = START_W - BYTE_W;
endpackage

// File: rtl/vfs_prio_pick.sv
module vfs_prio_pick #(
  parameter int N     = 7,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  logic [N:0] below;

  assign below[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign below[g+1]  = below[g] | req_i[g];
    assign grant_o[g]  = req_i[g] & ~below[g];
  end

  assign any_o = below[N];

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vfs_ctrl.sv
module vfs_ctrl
  import vfs_pkg::*;
#(
  parameter int N     = 7,
  parameter int PC_W  = 15,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reset_req_i,
  input  logic             req_any_i,
  input  logic [N-1:0]     grant_i,
  input  logic [IDX_W-1:0] grant_idx_i,
  output logic [N-1:0]     ack_o,
  output logic             save_o,
  output logic             busy_o,
  output logic             rd_o,
  output logic [PC_W-1:0]  addr_o,
  output logic             cap_hi_o,
  output logic             load_o
);
  seq_state_e      state_q;
  logic [PC_W-1:0] vec_q;
  logic [N-1:0]    ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_BOOT;
      vec_q   <= '0;
      ack_q   <= '0;
    end else begin
      ack_q <= '0;
      if (reset_req_i) begin
        state_q <= ST_RD_HI;
        vec_q   <= '0;
      end else begin
        unique case (state_q)
          ST_BOOT: begin
            state_q <= ST_RD_HI;
            vec_q   <= '0;
          end
          ST_IDLE: begin
            if (req_any_i) begin
              state_q <= ST_SAVE;
              vec_q   <= PC_W'({grant_idx_i, 1'b0}) + PC_W'(2);
              ack_q   <= grant_i;
            end
          end
          ST_SAVE:  state_q <= ST_RD_HI;
          ST_RD_HI: state_q <= ST_RD_LO;
          ST_RD_LO: state_q <= ST_FIN;
          ST_FIN:   state_q <= ST_IDLE;
          default:  state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign ack_o    = ack_q;
  assign save_o   = (state_q == ST_SAVE);
  assign busy_o   = (state_q != ST_IDLE);
  assign rd_o     = (state_q == ST_RD_HI) || (state_q == ST_RD_LO);
  assign addr_o   = vec_q | PC_W'(state_q == ST_RD_LO);
  assign cap_hi_o = (state_q == ST_RD_LO);
  assign load_o   = (state_q == ST_FIN) && !reset_req_i;

  assert_ack_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o));

  assert_save_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_o |=> !save_o);

  assert_save_before_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_o |=> (rd_o && !addr_o[0]));

  assert_hi_then_lo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_HI && !reset_req_i) |=> (rd_o && addr_o == $past(addr_o) + PC_W'(1)));

  assert_ack_from_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_o) |-> $past(state_q == ST_IDLE));
endmodule

// File: rtl/vfs_load.sv
module vfs_load
  import vfs_pkg::*;
#(
  parameter int PC_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_hi_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              mbe_o,
  output logic              rbe_o
);
  logic [BYTE_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      pc_o  <= '0;
      mbe_o <= 1'b0;
      rbe_o <= 1'b0;
    end else begin
      if (cap_hi_i) hi_q <= data_i;
      if (load_i) begin
        pc_o  <= PC_W'({hi_q[HI_ADR_W-1:0], data_i});
        mbe_o <= hi_q[MBE_BIT];
        rbe_o <= hi_q[RBE_BIT];
      end
    end
  end

  assert_pc_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_o >> START_W) == '0);
endmodule

// File: rtl/vector_fetch_seq.sv
module vector_fetch_seq
  import vfs_pkg::*;
#(
  parameter int NUM_IRQ = 7,
  parameter int PC_W    = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reset_req_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  output logic [NUM_IRQ-1:0] irq_ack_o,
  output logic               rom_rd_o,
  output logic [PC_W-1:0]    rom_addr_o,
  input  logic [7:0]         rom_data_i,
  output logic [PC_W-1:0]    pc_o,
  output logic               mbe_o,
  output logic               rbe_o,
  output logic               save_o,
  output logic               busy_o
);
  localparam int IDX_W = $clog2(NUM_IRQ);

  logic [NUM_IRQ-1:0] grant;
  logic [IDX_W-1:0]   grant_idx;
  logic               req_any;
  logic               cap_hi;
  logic               load;

  vfs_prio_pick #(.N(NUM_IRQ), .IDX_W(IDX_W)) u_pick (
    .req_i   (irq_i),
    .grant_o (grant),
    .idx_o   (grant_idx),
    .any_o   (req_any)
  );

  vfs_ctrl #(.N(NUM_IRQ), .PC_W(PC_W), .IDX_W(IDX_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reset_req_i (reset_req_i),
    .req_any_i   (req_any),
    .grant_i     (grant),
    .grant_idx_i (grant_idx),
    .ack_o       (irq_ack_o),
    .save_o      (save_o),
    .busy_o      (busy_o),
    .rd_o        (rom_rd_o),
    .addr_o      (rom_addr_o),
    .cap_hi_o    (cap_hi),
    .load_o      (load)
  );

  vfs_load #(.PC_W(PC_W)) u_load (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_hi_i (cap_hi),
    .load_i   (load),
    .data_i   (rom_data_i),
    .pc_o     (pc_o),
    .mbe_o    (mbe_o),
    .rbe_o    (rbe_o)
  );

  assert_pc_hold_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $stable(pc_o));

  assert_read_only_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_rd_o |-> busy_o);

  assert_ack_grant_owner_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_ack_o) |-> ((irq_ack_o & $past(irq_i)) == irq_ack_o));
endmodule

// File: tb/sim_vector_fetch_seq.sv
module sim_vector_fetch_seq;
  localparam int N    = 7;
  localparam int PC_W = 15;
  localparam int NV   = 10;
  localparam logic [N-1:0] PAT [0:NV-1] = '{
    7'b0000001, 7'b0000010, 7'b0000100, 7'b0001000, 7'b0010000,
    7'b0100000, 7'b1000000, 7'b1100100, 7'b1111110, 7'b1010000};
  localparam int EXPI [0:NV-1] = '{0, 1, 2, 3, 4, 5, 6, 2, 1, 4};

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            reset_req = 1'b0;
  logic [N-1:0]    irq = '0;
  logic [N-1:0]    ack;
  logic            rom_rd;
  logic [PC_W-1:0] rom_addr;
  logic [7:0]      rom_q = 8'h00;
  logic [PC_W-1:0] pc;
  logic            mbe, rbe, save, busy;

  logic [7:0] rom_hi [0:7];
  logic [7:0] rom_lo [0:7];

  int checks = 0;
  int errs   = 0;
  int rd_n = 0, save_n = 0, ack_n = 0;
  logic [PC_W-1:0] rd_a [0:63];

  always #2 clk = ~clk;

  vector_fetch_seq #(.NUM_IRQ(N), .PC_W(PC_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reset_req_i(reset_req), .irq_i(irq),
    .irq_ack_o(ack), .rom_rd_o(rom_rd), .rom_addr_o(rom_addr), .rom_data_i(rom_q),
    .pc_o(pc), .mbe_o(mbe), .rbe_o(rbe), .save_o(save), .busy_o(busy));

  always @(posedge clk) begin
    if (rom_rd)
      rom_q <= (rom_addr < 16) ? (rom_addr[0] ? rom_lo[rom_addr[3:1]] : rom_hi[rom_addr[3:1]]) : 8'h00;
    if (rst_ni) begin
      if (rom_rd) begin
        rd_a[rd_n % 64] <= rom_addr;
        rd_n <= rd_n + 1;
      end
      if (save) save_n <= save_n + 1;
      if (|ack) ack_n <= ack_n + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [PC_W-1:0] vpc(input int k);
    return PC_W'({rom_hi[k][5:0], rom_lo[k]});
  endfunction

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 30) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic check_load(input string tag, input int k);
    chk({tag, " R2 pc"}, 32'(pc), 32'(vpc(k)));
    chk({tag, " R2 mbe"}, 32'(mbe), 32'(rom_hi[k][7]));
    chk({tag, " R2 rbe"}, 32'(rbe), 32'(rom_hi[k][6]));
  endtask

  task automatic run_irq(input logic [N-1:0] pat, input int e);
    int r0, s0, a0, n;
    logic [PC_W-1:0] pc_prev;
    @(negedge clk);
    r0 = rd_n; s0 = save_n; a0 = ack_n; pc_prev = pc;
    irq = pat;
    @(negedge clk);
    chk("R5 ack winner", 32'(ack), 32'(1 << e));
    chk("R7 busy after accept", 32'(busy), 1);
    irq = '0;
    n = 0;
    while (busy && n < 30) begin
      chk("R7 pc hold", 32'(pc), 32'(pc_prev));
      @(negedge clk);
      n++;
    end
    chk("R7 busy length", n, 4);
    chk("R10 read count", rd_n - r0, 2);
    chk("R4 vector address", 32'(rd_a[r0 % 64]), 32'(2 * e + 2));
    chk("R3 second address", 32'(rd_a[(r0 + 1) % 64]), 32'(2 * e + 3));
    chk("R6 save count", save_n - s0, 1);
    chk("R5 ack pulses", ack_n - a0, 1);
    check_load("irq", e + 1);
  endtask

  initial begin
    #(4 * 200000);
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    int n, r0, s0, a0;
    for (int k = 0; k < 8; k++) begin
      rom_hi[k] = 8'(k * 37 + 5);
      rom_lo[k] = 8'(k * 29 + 17);
    end

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 32'(busy), 1);
    chk("R1 rd in reset", 32'(rom_rd), 0);
    chk("R1 pc in reset", 32'(pc), 0);
    chk("R1 flags in reset", 32'({mbe, rbe}), 0);
    chk("R1 ack/save in reset", 32'({ack, save}), 0);
    rst_ni = 1'b1;
    wait_idle(n);
    chk("R1 boot length", n, 4);
    chk("R1 reads", rd_n, 2);
    chk("R1 first address", 32'(rd_a[0]), 0);
    chk("R1 second address", 32'(rd_a[1]), 1);
    chk("R6 no save on reset", save_n, 0);
    check_load("R1 boot", 0);

    // table of requests
    for (int i = 0; i < NV; i++) run_irq(PAT[i], EXPI[i]);

    // R9 request during busy
    @(negedge clk);
    a0 = ack_n;
    irq = 7'b0001000;
    @(negedge clk);
    chk("R9 first ack", 32'(ack), 32'(7'b0001000));
    irq = 7'b0000001;
    wait_idle(n);
    chk("R9 no ack while busy", ack_n - a0, 1);
    check_load("R9 first", 4);
    @(negedge clk);
    chk("R9 served after", 32'(ack), 1);
    irq = '0;
    wait_idle(n);
    check_load("R9 second", 1);

    // R8 reset request aborts an interrupt fetch
    @(negedge clk);
    irq = 7'b0100000;
    @(negedge clk);
    irq = '0;
    @(negedge clk);
    reset_req = 1'b1;
    @(negedge clk);
    reset_req = 1'b0;
    wait_idle(n);
    chk("R8 restart address hi", 32'(rd_a[(rd_n - 2) % 64]), 0);
    chk("R8 restart address lo", 32'(rd_a[(rd_n - 1) % 64]), 1);
    check_load("R8 abort", 0);

    // R8 reset request beats a pending request in idle
    @(negedge clk);
    a0 = ack_n; s0 = save_n;
    irq = 7'b0000100;
    reset_req = 1'b1;
    @(negedge clk);
    reset_req = 1'b0;
    chk("R8 no ack", 32'(ack), 0);
    chk("R8 reading reset pair", 32'({rom_rd, rom_addr}), 32'({1'b1, 15'h0}));
    wait_idle(n);
    chk("R8 ack count", ack_n - a0, 0);
    chk("R6 no save on reset request", save_n - s0, 0);
    @(negedge clk);
    chk("R9 pending served after reset", 32'(ack), 32'(7'b0000100));
    irq = '0;
    wait_idle(n);
    check_load("R9 after reset", 3);

    // R2 flags set, widest start address
    rom_hi[0] = 8'hFF;
    rom_lo[0] = 8'hFF;
    @(negedge clk);
    r0 = rd_n;
    reset_req = 1'b1;
    @(negedge clk);
    reset_req = 1'b0;
    wait_idle(n);
    chk("R2 top address", 32'(pc), 32'h3FFF);
    chk("R2 both flags", 32'({mbe, rbe}), 32'b11);
    chk("R10 reads", rd_n - r0, 2);
    repeat (3) @(negedge clk);
    chk("R10 idle no read", 32'(rom_rd), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule